// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block is the running time-of-day and calendar counter of a timekeeping RAM. A clock-enable input, pulsed at the crystal rate (32768 per second by default), feeds a binary prescaler. The prescaler produces a once-per-second advance for a chain of packed-BCD fields: seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and a two-digit century. Month lengths and February of leap years are handled inside the chain. A year counts as a leap year when its two-digit value is divisible by four, which holds up to the end of the century.

The parallel load port carries a complete set of field values. Software uses it when a set-time operation is released. Bit 7 of the loaded seconds byte is the stop bit. While it is set, the prescaler is held clear and every field is frozen. A frequency-test enable routes a prescaler tap to a square-wave output. At the default tap this output runs at 512 Hz.

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the fields read seconds 00 with the stop bit clear, minutes 00, hours 00, day of week 1, date 01, month 01, year 00 and century 20. `load_ready` is 1, and `test_wave` is 0 while `ft_en` is 0.
- R2: With the stop bit clear, the time advances by one second on every 2^DIV_BITS-th cycle in which `tick_en` is 1. Cycles with `tick_en` at 0 do not count. The count restarts from zero after every accepted load.
- R3: Seconds and minutes count 00..59 in BCD. Each wraps to 00 and carries one into the next field.
- R4: Hours count 00..23. Passing 23:59:59 gives 00:00:00 and advances both the day of week and the date.
- R5: Day of week counts 1..7, and at midnight it goes from 7 back to 1.
- R6: The date wraps to 01 and carries into the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11.
- R7: February ends after day 29 when the BCD year is divisible by four (year 00 included) and after day 28 otherwise.
- R8: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century. Century 99 wraps to 00.
- R9: Bit 7 of `sec_o` is the stop bit, taken from `ld_sec[7]` on a load. While it is 1, no field changes and the prescaler stays clear.
- R10: A load is accepted on a clock edge where `load_valid` and `load_ready` are both 1. All fields then take the `ld_*` values on that edge. `load_ready` is 0 only in a cycle that commits a one-second advance, and a held `load_valid` is accepted on the next edge.
- R11: When `ft_en` is 1 and the stop bit is clear, `test_wave` equals bit TEST_TAP of the prescaler count, so it toggles every 2^TEST_TAP enables. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Crystal-rate count enable |
| ft_en | input | 1 | Frequency-test enable for `test_wave` |
| load_valid | input | 1 | Parallel load request |
| load_ready | output | 1 | Load can be taken this cycle |
| ld_sec | input | 8 | Load seconds; bit 7 is the stop bit |
| ld_min | input | 8 | Load minutes (BCD) |
| ld_hour | input | 8 | Load hours, 24-hour (BCD) |
| ld_dow | input | 8 | Load day of week 1..7 |
| ld_date | input | 8 | Load date (BCD) |
| ld_month | input | 8 | Load month (BCD) |
| ld_year | input | 8 | Load year (BCD) |
| ld_cent | input | 8 | Load century (BCD) |
| sec_o | output | 8 | Seconds (BCD) with stop bit in bit 7 |
| min_o | output | 8 | Minutes (BCD) |
| hour_o | output | 8 | Hours (BCD) |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Date (BCD) |
| month_o | output | 8 | Month (BCD) |
| year_o | output | 8 | Year (BCD) |
| cent_o | output | 8 | Century (BCD) |
| test_wave | output | 1 | Prescaler tap square wave |

## Verification
Several properties are checked on every cycle:
- A set stop bit freezes the fields.
- An accepted load lands on the next edge.
- The seconds field moves only after a load or a committed second.
- `load_ready` drops only with such a second.
- Hours and dates stay in their legal BCD ranges.

Only the bench scenarios can show that the rollover values are correct: month lengths, the leap-year choice, the year and century carries, and the day-of-week wrap. The exact enable count per second and the tap waveform also depend on those scenarios.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int NF     = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  typedef logic [7:0] bcd8_t;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    logic [3:0] hi, lo;
    hi = v[7:4];
    lo = v[3:0];
    if (lo >= 4'd9) return {hi + 4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

  function automatic int bcd_to_bin(bcd8_t v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic is_leap(bcd8_t year);
    return (bcd_to_bin(year) % 4) == 0;
  endfunction

  function automatic bcd8_t month_last_day(bcd8_t month, logic leap);
    case (month)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd8_t field_reset(int idx);
    case (idx)
      F_DOW, F_DATE, F_MON: return 8'h01;
      F_CENT:               return 8'h20;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t field_low(int idx);
    case (idx)
      F_DOW, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t field_max(int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_DATE:       return 8'h31;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

endpackage

// File: rtl/bcd_prescaler.sv
module bcd_prescaler #(
  parameter int DIV_BITS = 15,
  parameter int TEST_TAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic halt,
  input  logic clear,
  output logic sec_tick,
  output logic tap_bit
);

  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (halt || clear)   cnt_q <= '0;
    else if (tick_en)         cnt_q <= cnt_q + 1'b1;
  end

  assign sec_tick = tick_en && !halt && (&cnt_q);
  assign tap_bit  = cnt_q[TEST_TAP];

endmodule

// File: rtl/bcd_field_reg.sv
module bcd_field_reg
  import bcd_cal_pkg::*;
#(
  parameter bcd8_t RESET_VAL = 8'h00,
  parameter bcd8_t LOW_VAL   = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  bcd8_t load_val,
  input  logic  step,
  input  logic  at_top,
  output bcd8_t value
);

  bcd8_t val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      val_q <= RESET_VAL;
    else if (load)   val_q <= load_val;
    else if (step)   val_q <= at_top ? LOW_VAL : bcd_inc(val_q);
  end

  assign value = val_q;

endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
  import bcd_cal_pkg::*;
#(
  parameter int DIV_BITS = 15,
  parameter int TEST_TAP = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ft_en,
  input  logic       load_valid,
  output logic       load_ready,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_cent,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o,
  output logic       test_wave
);

  logic  stop_q;
  logic  sec_tick;
  logic  tap_bit;
  logic  load_acc;
  bcd8_t val   [NF];
  bcd8_t lim   [NF];
  bcd8_t ld_v  [NF];
  logic  at_top[NF];
  logic  step  [NF];

  assign load_ready = !sec_tick;
  assign load_acc   = load_valid && load_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        stop_q <= 1'b0;
    else if (load_acc) stop_q <= ld_sec[7];
  end

  bcd_prescaler #(
    .DIV_BITS(DIV_BITS),
    .TEST_TAP(TEST_TAP)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .halt    (stop_q),
    .clear   (load_acc),
    .sec_tick(sec_tick),
    .tap_bit (tap_bit)
  );

  always_comb begin
    ld_v[F_SEC]  = {1'b0, ld_sec[6:0]};
    ld_v[F_MIN]  = ld_min;
    ld_v[F_HOUR] = ld_hour;
    ld_v[F_DOW]  = ld_dow;
    ld_v[F_DATE] = ld_date;
    ld_v[F_MON]  = ld_month;
    ld_v[F_YEAR] = ld_year;
    ld_v[F_CENT] = ld_cent;
  end

  always_comb begin
    for (int i = 0; i < NF; i++) lim[i] = field_max(i);
    lim[F_DATE] = month_last_day(val[F_MON], is_leap(val[F_YEAR]));
    for (int i = 0; i < NF; i++) at_top[i] = (val[i] >= lim[i]);
  end

  // carry network: date and day of week both follow the hour wrap
  always_comb begin
    step[F_SEC]  = sec_tick;
    step[F_MIN]  = step[F_SEC]  && at_top[F_SEC];
    step[F_HOUR] = step[F_MIN]  && at_top[F_MIN];
    step[F_DOW]  = step[F_HOUR] && at_top[F_HOUR];
    step[F_DATE] = step[F_HOUR] && at_top[F_HOUR];
    step[F_MON]  = step[F_DATE] && at_top[F_DATE];
    step[F_YEAR] = step[F_MON]  && at_top[F_MON];
    step[F_CENT] = step[F_YEAR] && at_top[F_YEAR];
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    bcd_field_reg #(
      .RESET_VAL(field_reset(i)),
      .LOW_VAL  (field_low(i))
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_acc),
      .load_val(ld_v[i]),
      .step    (step[i]),
      .at_top  (at_top[i]),
      .value   (val[i])
    );
  end

  assign sec_o     = {stop_q, val[F_SEC][6:0]};
  assign min_o     = val[F_MIN];
  assign hour_o    = val[F_HOUR];
  assign dow_o     = val[F_DOW];
  assign date_o    = val[F_DATE];
  assign month_o   = val[F_MON];
  assign year_o    = val[F_YEAR];
  assign cent_o    = val[F_CENT];
  assign test_wave = ft_en && !stop_q && tap_bit;

endmodule

// File: rtl/bcd_calendar_chain_chk.sv
module bcd_calendar_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_acc,
  input logic       load_ready,
  input logic       sec_tick,
  input logic [7:0] ld_min,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic       test_wave
);

  assert_load_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> (min_o == $past(ld_min)));

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ready |-> sec_tick);

  assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !load_acc) |=> ($stable(sec_o) && $stable(min_o) &&
                                 $stable(hour_o) && $stable(date_o)));

  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[7] |-> !test_wave);

  assert_sec_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_o[6:0]) |-> ($past(load_acc) || $past(sec_tick)));

  assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_o <= 8'h23) && (hour_o[3:0] <= 4'd9));

  assert_date_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (date_o != 8'h00) && (date_o <= 8'h31));

endmodule

bind bcd_calendar_chain bcd_calendar_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_acc  (load_valid && load_ready),
  .load_ready(load_ready),
  .sec_tick  (sec_tick),
  .ld_min    (ld_min),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .date_o    (date_o),
  .test_wave (test_wave)
);

// File: tb/tb_bcd_calendar_chain.sv
module tb_bcd_calendar_chain;

  localparam int DIV    = 4;
  localparam int TAP    = 1;
  localparam int SEC_EN = 1 << DIV;
  localparam int NV     = 16;

  // {start, expected}, each {cent,year,month,date,dow,hour,min,sec}
  localparam logic [127:0] VEC [NV] = '{
    {64'h20_24_03_15_03_10_20_30, 64'h20_24_03_15_03_10_20_31},
    {64'h20_24_03_15_03_10_20_59, 64'h20_24_03_15_03_10_21_00},
    {64'h20_24_03_15_03_10_59_59, 64'h20_24_03_15_03_11_00_00},
    {64'h20_24_03_15_03_23_59_59, 64'h20_24_03_16_04_00_00_00},
    {64'h20_24_03_16_07_23_59_59, 64'h20_24_03_17_01_00_00_00},
    {64'h20_23_04_30_02_23_59_59, 64'h20_23_05_01_03_00_00_00},
    {64'h20_23_01_31_01_23_59_59, 64'h20_23_02_01_02_00_00_00},
    {64'h20_23_02_28_03_23_59_59, 64'h20_23_03_01_04_00_00_00},
    {64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00},
    {64'h20_24_02_29_04_23_59_59, 64'h20_24_03_01_05_00_00_00},
    {64'h20_23_12_31_07_23_59_59, 64'h20_24_01_01_01_00_00_00},
    {64'h20_99_12_31_04_23_59_59, 64'h21_00_01_01_05_00_00_00},
    {64'h20_23_09_30_05_23_59_59, 64'h20_23_10_01_06_00_00_00},
    {64'h20_23_11_30_04_23_59_59, 64'h20_23_12_01_05_00_00_00},
    {64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00},
    {64'h99_99_12_31_05_23_59_59, 64'h00_00_01_01_06_00_00_00}
  };
  localparam string VREQ [NV] = '{"R2", "R3", "R3", "R4", "R5", "R6", "R6", "R7",
                                  "R7", "R7", "R8", "R8", "R6", "R6", "R7", "R8"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic ft_en = 1'b0;
  logic load_valid = 1'b0;
  logic load_ready;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
  logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0, ld_cent = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;
  logic test_wave;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_calendar_chain #(.DIV_BITS(DIV), .TEST_TAP(TAP)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ft_en(ft_en),
    .load_valid(load_valid), .load_ready(load_ready),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
    .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_cent(ld_cent),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o),
    .test_wave(test_wave)
  );

  wire [63:0] now = {cent_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_load(logic [63:0] t);
    {ld_cent, ld_year, ld_month, ld_date, ld_dow, ld_hour, ld_min, ld_sec} = t;
    load_valid = 1'b1;
  endtask

  task automatic load_time(logic [63:0] t);
    put_load(t);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic advance(int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", now, 64'h20_00_01_01_01_00_00_00);
    check("R1", {63'd0, load_ready}, 64'd1);
    check("R1", {63'd0, test_wave}, 64'd0);

    // table walk: each vector loads a start time and advances one second
    for (int k = 0; k < NV; k++) begin
      load_time(VEC[k][127:64]);
      advance(SEC_EN);
      check(VREQ[k], now, VEC[k][63:0]);
    end

    // R2: exact enable count, idle cycles do not count
    load_time(64'h20_24_03_15_03_10_20_30);
    advance(SEC_EN - 1);
    check("R2", now, 64'h20_24_03_15_03_10_20_30);
    repeat (3) @(negedge clk);
    check("R2", now, 64'h20_24_03_15_03_10_20_30);
    advance(1);
    check("R2", now, 64'h20_24_03_15_03_10_20_31);
    advance(SEC_EN * 3);
    check("R2", now, 64'h20_24_03_15_03_10_20_34);

    // R9: stop bit freezes the chain and silences the test wave (R11)
    ft_en = 1'b1;
    load_time(64'h20_24_03_15_03_10_20_90);
    advance(SEC_EN * 3 + 5);
    check("R9", now, 64'h20_24_03_15_03_10_20_90);
    check("R11", {63'd0, test_wave}, 64'd0);
    ft_en = 1'b0;
    load_time(64'h20_24_03_15_03_10_20_10);
    advance(SEC_EN);
    check("R9", now, 64'h20_24_03_15_03_10_20_11);

    // R10: load held across a committed second
    load_time(64'h20_24_03_15_03_10_20_40);
    advance(SEC_EN - 1);
    tick_en = 1'b1;
    put_load(64'h20_11_06_07_02_08_09_05);
    #1;
    check("R10", {63'd0, load_ready}, 64'd0);
    @(negedge clk);
    tick_en = 1'b0;
    check("R10", now, 64'h20_24_03_15_03_10_20_41);
    check("R10", {63'd0, load_ready}, 64'd1);
    @(negedge clk);
    load_valid = 1'b0;
    check("R10", now, 64'h20_11_06_07_02_08_09_05);

    // R11: test wave follows prescaler tap bit
    ft_en = 1'b1;
    load_time(64'h20_24_03_15_03_10_20_00);
    check("R11", {63'd0, test_wave}, 64'd0);
    for (int k = 1; k <= 6; k++) begin
      advance(1);
      check("R11", {63'd0, test_wave}, 64'((k >> TAP) & 1));
    end
    ft_en = 1'b0;
    #1;
    check("R11", {63'd0, test_wave}, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule